// File: doc/BRIEF.md
# Multichannel PCM Audio Serializer

This block is the transmit side of a serial audio output port. It takes 24-bit PCM samples from a parallel holding bus and shifts them out, MSB first, on four serial data lines. All four lines share one bit clock, which is an input, and one frame clock, which the block generates. The frame clock period is one sampling period. In stereo mode each line carries a left/right pair. The framing is either I2S or left-justified.

A multichannel mode puts four or six channels on data line 0 alone, one after another in a single frame. A separate select hands data line 3 to an S/PDIF bitstream that an external encoder supplies. The source stores the next set of samples on the holding bus. The block copies that set at the start of each frame and raises a one-cycle request for the following set. All logic runs on the falling edge of the bit clock, so a receiver can sample on the rising edge.

Top module: `pcm_serializer`

## Requirements
- R1: While `enable` is low, including directly after reset, the block holds all four data lines low and `smp_req` low. This holds even when the S/PDIF select is set. The frame clock rests in its left-channel level: high for left-justified and low for I2S.
- R2: A frame lasts 64 bit clocks in stereo mode, 128 in four-channel mode and 192 in six-channel mode. The frame clock shows the left-channel level for the first half of the frame and the opposite level for the second half. The left-channel level is high when `fmt_lj`=1 and low when `fmt_lj`=0.
- R3: `smp_req` is high for exactly one bit clock, during the first bit clock of every frame, including the first frame after `enable` rises. The frame carries the values that were on `smp_in` at the falling edge that started it. Later changes to `smp_in` during the frame have no effect on it.
- R4: Each channel slot is 32 bit clocks long. The 24 sample bits come first, MSB first, and the 8 bits after the LSB are zero.
- R5: With `fmt_lj`=1 (left-justified), the MSB of a slot appears in the same bit clock as the start of the slot.
- R6: With `fmt_lj`=0 (I2S), every data bit appears one bit clock later than in left-justified mode. The MSB of a slot therefore follows the start of the slot by one bit clock.
- R7: In stereo mode (`mch_sel` 00 or 11), line L carries channel 2L in the left half and channel 2L+1 in the right half. Channel k is `smp_in[24k+23:24k]`.
- R8: When `mch_sel`=01 (four channels) or 10 (six channels), line 0 carries channels 0 up to N-1 in ascending slots. Lines 1 and 2 stay low, and line 3 stays low unless the S/PDIF select is set.
- R9: While enabled with `spdif_sel`=1, line 3 follows `spdif_in` combinationally, and lines 0 to 2 are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the port; low forces the idle state |
| fmt_lj | input | 1 | 1 selects left-justified framing, 0 selects I2S |
| mch_sel | input | 2 | 00/11 stereo on all lines, 01 four channels on line 0, 10 six channels on line 0 |
| spdif_sel | input | 1 | Gives data line 3 to the S/PDIF stream |
| spdif_in | input | 1 | Encoded S/PDIF bitstream from an external encoder |
| smp_in | input | 192 | Eight 24-bit channel holding words, channel k at bits 24k+23:24k |
| smp_req | output | 1 | One-cycle request for the next sample set |
| lrclk | output | 1 | Frame clock |
| sdata | output | 4 | Serial data lines 0 to 3 |

## Verification
The bench checks every bit clock of whole frames in each mode and format. It looks at bit-offset and padding errors, such as an I2S stream that is not delayed or a word that carries the LSB into the pad. A design with either error shows a wrong bit at a slot boundary. All-ones samples expose pad bits that are not zeroed, and a 0x800001 pattern exposes a shift that is one bit too far. The bench changes the holding bus straight after each request, so a design that reads the bus while a frame is under way sends bits from the wrong set. In the multichannel modes, a wrong channel order or a stray write to lines 1 to 3 shows up as a bit mismatch. The idle checks with the S/PDIF select set catch a line 3 mux that escapes the disable.

// File: rtl/pcm_serializer.sv
module pcm_serializer #(
  parameter int SW    = 24,
  parameter int SLOT  = 32,
  parameter int LINES = 4
) (
  input  logic                  sclk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  fmt_lj,
  input  logic [1:0]            mch_sel,
  input  logic                  spdif_sel,
  input  logic                  spdif_in,
  input  logic [2*LINES*SW-1:0] smp_in,
  output logic                  smp_req,
  output logic                  lrclk,
  output logic [LINES-1:0]      sdata
);
  localparam int NCH    = 2 * LINES;
  localparam int CHW    = $clog2(NCH);
  localparam int SLOT_W = $clog2(SLOT);
  localparam int CW     = $clog2(6 * SLOT) + 1;
  localparam logic [SLOT_W:0] SW_C = (SLOT_W + 1)'(SW);

  logic [SW-1:0]    cur [NCH];
  logic [CW-1:0]    cnt, fl, pos;
  logic             run, multi, last, left, in_word;
  logic [CHW-1:0]   slot;
  logic [SLOT_W-1:0] bitp;
  logic [LINES-1:0] pcm;

  assign multi = (mch_sel == 2'b01) || (mch_sel == 2'b10);

  always_comb begin
    case (mch_sel)
      2'b01:   fl = CW'(4 * SLOT);
      2'b10:   fl = CW'(6 * SLOT);
      default: fl = CW'(2 * SLOT);
    endcase
  end

  assign last    = cnt >= fl - 1'b1;
  assign pos     = fmt_lj ? cnt : ((cnt == '0) ? fl - 1'b1 : cnt - 1'b1);
  assign slot    = CHW'(pos >> SLOT_W);
  assign bitp    = pos[SLOT_W-1:0];
  assign in_word = {1'b0, bitp} < SW_C;
  assign left    = !run || (cnt < (fl >> 1));
  assign lrclk   = fmt_lj ? left : !left;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      smp_req <= 1'b0;
      for (int k = 0; k < NCH; k++) cur[k] <= '0;
    end else begin
      smp_req <= 1'b0;
      if (!enable) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (!run || last) begin
        run     <= 1'b1;
        cnt     <= '0;
        smp_req <= 1'b1;
        for (int k = 0; k < NCH; k++) cur[k] <= smp_in[k*SW +: SW];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar L = 0; L < LINES; L++) begin : g_line
    logic [CHW-1:0] ch;
    logic [SW-1:0]  word;
    assign ch     = multi ? slot : CHW'(2 * L) + {{(CHW-1){1'b0}}, slot[0]};
    assign word   = cur[ch] << bitp;
    assign pcm[L] = run && in_word && word[SW-1] && (!multi || (L == 0));
  end

  assign sdata[LINES-2:0] = pcm[LINES-2:0];
  assign sdata[LINES-1]   = (run && spdif_sel) ? spdif_in : pcm[LINES-1];
endmodule

// File: rtl/pcm_serializer_sva.sv
module pcm_serializer_sva (
  input logic       sclk,
  input logic       rst_n,
  input logic       enable,
  input logic       fmt_lj,
  input logic [1:0] mch_sel,
  input logic       spdif_sel,
  input logic       spdif_in,
  input logic       smp_req,
  input logic       lrclk,
  input logic [3:0] sdata
);
  AST_IDLE_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    !enable |-> (sdata == 4'b0000) && (lrclk == fmt_lj) && !smp_req); // R1
  AST_REQ_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n)
    smp_req |=> !smp_req); // R3
  AST_REQ_AT_LEFT: assert property (@(posedge sclk) disable iff (!rst_n)
    smp_req |-> lrclk == fmt_lj); // R2
  AST_MCH_LINES_LOW: assert property (@(posedge sclk) disable iff (!rst_n)
    (mch_sel == 2'b01 || mch_sel == 2'b10) |-> sdata[2:1] == 2'b00); // R8
  AST_SPDIF_PASS: assert property (@(posedge sclk) disable iff (!rst_n)
    (enable && spdif_sel) |-> sdata[3] == spdif_in); // R9
endmodule

bind pcm_serializer pcm_serializer_sva u_sva (
  .sclk(sclk), .rst_n(rst_n), .enable(enable), .fmt_lj(fmt_lj),
  .mch_sel(mch_sel), .spdif_sel(spdif_sel), .spdif_in(spdif_in),
  .smp_req(smp_req), .lrclk(lrclk), .sdata(sdata)
);

// File: tb/test_pcm_serializer.sv
module test_pcm_serializer;
  logic         clk = 1'b0;
  logic         rst_n, enable, fmt_lj, spdif_sel, spdif_in;
  logic [1:0]   mch_sel;
  logic [191:0] smp_in;
  logic         smp_req, lrclk;
  logic [3:0]   sdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [23:0] nxt [8];
  logic [23:0] cur_exp [8];

  always #4 clk = ~clk;

  pcm_serializer i_pcm_serializer (
    .sclk(clk), .rst_n(rst_n), .enable(enable), .fmt_lj(fmt_lj),
    .mch_sel(mch_sel), .spdif_sel(spdif_sel), .spdif_in(spdif_in),
    .smp_in(smp_in), .smp_req(smp_req), .lrclk(lrclk), .sdata(sdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic fill(input int pat);
    for (int k = 0; k < 8; k++) begin
      nxt[k] = (pat == 1) ? 24'hFFFFFF : (pat == 2) ? 24'h800001 : 24'($urandom);
      smp_in[k*24 +: 24] = nxt[k];
    end
  endtask

  function automatic int nch_of(input logic [1:0] ms);
    return (ms == 2'b01) ? 4 : (ms == 2'b10) ? 6 : 2;
  endfunction

  function automatic logic exp_bit(input int line, input int i, input int nch, input bit lj);
    int fl = 32 * nch;
    int p  = lj ? i : (i + fl - 1) % fl;
    int s  = p / 32;
    int b  = p % 32;
    int ch;
    if (nch != 2 && line != 0) return 1'b0;
    ch = (nch == 2) ? 2 * line + s : s;
    return (b < 24) ? cur_exp[ch][23 - b] : 1'b0;
  endfunction

  task automatic run_mode(input logic [1:0] ms, input bit lj, input bit sp, input int nfr, input int pat);
    int nch = nch_of(ms);
    int fl  = 32 * nch;
    enable = 1'b0;
    @(posedge clk);
    spdif_sel = 1'b1; spdif_in = 1'b1; mch_sel = ms; fmt_lj = lj;
    fill(pat);
    @(posedge clk);
    repeat (2) begin
      chk("R1 idle data", sdata, 0);
      chk("R1 idle lrclk", lrclk, lj);
      chk("R1 idle req", smp_req, 0);
      @(posedge clk);
    end
    spdif_sel = sp; spdif_in = 1'b0; enable = 1'b1;
    @(posedge clk);
    chk("R3 first req", smp_req, 1);
    for (int f = 0; f < nfr; f++) begin
      for (int k = 0; k < 8; k++) cur_exp[k] = nxt[k];
      fill(0); // R3: bus changes right after the frame starts
      for (int i = 0; i < fl; i++) begin
        int p = lj ? i : (i + fl - 1) % fl;
        string tag;
        chk("R2 lrclk", lrclk, (i < fl / 2) ? lj : !lj);
        chk("R3 req", smp_req, (i == 0) ? 1 : 0);
        for (int L = 0; L < 4; L++) begin
          if (L == 3 && sp) begin
            chk("R9 spdif line3", sdata[3], spdif_in);
          end else begin
            if (p % 32 >= 24)   tag = "R4 pad";
            else if (nch != 2) tag = "R8 multi";
            else if (L != 0)   tag = "R7 pair";
            else               tag = lj ? "R5 lj" : "R6 i2s";
            chk(tag, sdata[L], exp_bit(L, i, nch, lj));
          end
        end
        spdif_in = 1'($urandom);
        @(posedge clk);
      end
    end
    chk("R3 next frame req", smp_req, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; enable = 1'b0; fmt_lj = 1'b0; mch_sel = 2'b00;
    spdif_sel = 1'b0; spdif_in = 1'b0; smp_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    chk("R1 reset data", sdata, 0);
    chk("R1 reset lrclk", lrclk, 0);
    chk("R1 reset req", smp_req, 0);
    run_mode(2'b00, 1'b1, 1'b0, 3, 1);
    run_mode(2'b00, 1'b0, 1'b0, 3, 2);
    run_mode(2'b01, 1'b1, 1'b0, 2, 0);
    run_mode(2'b01, 1'b0, 1'b0, 2, 1);
    run_mode(2'b10, 1'b1, 1'b0, 2, 2);
    run_mode(2'b10, 1'b0, 1'b0, 2, 0);
    run_mode(2'b11, 1'b0, 1'b0, 2, 0);
    run_mode(2'b00, 1'b1, 1'b1, 2, 0);
    run_mode(2'b10, 1'b0, 1'b1, 2, 1);
    enable = 1'b0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule